// File: doc/BRIEF.md
# Pushbutton Power Sequencing Controller

This block turns one active-low pushbutton into the start-up and shut-down sequence for two switching regulators. When the unit is off, a press that is held long enough starts a chained power-up. Regulator 1 is enabled first. Regulator 2 follows once regulator 1 reports that it is in regulation. The power-good line is released after a settling delay that starts when regulator 2 reports that it is in regulation. When the unit is on, a much longer press sends it into a timed power-down. After that it rests in hard reset and waits for a fresh press.

The button passes through a two-flop synchronizer before any timing logic sees it. The two "in regulation" flags come from external comparators and are taken to be synchronous to the clock. Every duration is a parameter counted in clock cycles, and one shared counter times all of them. The power-good output is open-drain: it drives low when it is deasserted and goes high-impedance when it is asserted. A 3-bit state code is brought out for debug.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, both enables are low, power-good drives low, the state code reads 0 (hard reset), and the "button seen high" flag is cleared.
- R2: A press is accepted only after the synchronized button has been seen high since the last reset or power-down. A button held low from reset onward never starts a power-up.
- R3: From hard reset, the button must stay low for PRESS_CYC consecutive synchronized cycles before a power-up starts. If the input `onN` is held low for at least PRESS_CYC+1 cycles, regulator 1 is enabled exactly PRESS_CYC+3 clock edges after the falling input, with regulator 2 still off. If it is held for PRESS_CYC cycles or fewer, nothing is enabled, and the next press counts from zero.
- R4: With regulator 1 enabled, regulator 2 is enabled on the first clock edge at which the regulator 1 flag is sampled high. Regulator 2 is never enabled while regulator 1 is off.
- R5: Once regulator 2 is enabled, power-good is released on the PG_DLY_CYC+1-th edge after the regulator 2 flag is first sampled high. Power-good is released only while both regulators are enabled.
- R6: If either regulation flag is low during the power-good delay, power-good stays low and the delay restarts. Power-good is then released on the PG_DLY_CYC-th edge after both flags are sampled good again.
- R7: While powered (state 5), holding `onN` low for LONG_CYC cycles enters power-down on the LONG_CYC+2-th edge, and a shorter hold has no effect. On entry to power-down, both enables fall and power-good drives low on the same edge.
- R8: Power-down (state 6) lasts exactly PDN_CYC clock edges and then moves to hard reset.
- R9: A button held low through the whole power-down does not start a power-up afterwards. The button must be released and then held low for a new full press.
- R10: The state code values are: 0 hard reset, 1 press qualification, 2 regulator 1 enabled, 3 regulator 2 enabled, 4 power-good delay, 5 powered, 6 power-down. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| onN | input | 1 | Pushbutton, active low, asynchronous |
| reg1Ok | input | 1 | Regulator 1 within regulation |
| reg2Ok | input | 1 | Regulator 2 within regulation |
| reg1En | output | 1 | Enable for regulator 1 |
| reg2En | output | 1 | Enable for regulator 2 |
| pwrGood | output | 1 | Power-good, open-drain: 0 when deasserted, high-impedance when asserted |
| stateCode | output | 3 | Current sequencing state for debug |

## Verification
Button events take two synchronizer edges before the state machine sees them. A press therefore raises regulator 1 PRESS_CYC+3 edges after `onN` falls, and a long press shuts the unit down LONG_CYC+2 edges after `onN` falls. A flag change shows on the enables or on power-good one edge later, plus the programmed delay. The power-down state ends PDN_CYC edges after it is entered. The bench drives every input just after a falling clock edge and counts falling edges from that point. At the last count before each of these edges it checks that the output has not yet changed, and at the count of the edge itself it checks the new value. The press and long-press lengths are swept across the acceptance boundary, one cycle on each side.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_HRST  = 3'd0,
    ST_PRESS = 3'd1,
    ST_EN1   = 3'd2,
    ST_EN2   = 3'd3,
    ST_PGDLY = 3'd4,
    ST_ON    = 3'd5,
    ST_PDN   = 3'd6
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;   // reload shared counter to zero
    logic seenClr;  // forget that the button was seen released
  } ctlStrobe_t;

endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int unsigned PRESS_CYC  = 400,
  parameter int unsigned PG_DLY_CYC = 230,
  parameter int unsigned PDN_CYC    = 1000,
  parameter int unsigned LONG_CYC   = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       onN,
  input  ctlStrobe_t strb,
  output logic       btnLow,
  output logic       seenHigh,
  output logic       pressDone,
  output logic       pgDone,
  output logic       pdnDone,
  output logic       longDone
);

  localparam int unsigned MAX_AB  = (PRESS_CYC > PG_DLY_CYC) ? PRESS_CYC : PG_DLY_CYC;
  localparam int unsigned MAX_CD  = (PDN_CYC > LONG_CYC) ? PDN_CYC : LONG_CYC;
  localparam int unsigned MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [CNT_W-1:0] PRESS_LAST = CNT_W'(PRESS_CYC - 1);
  localparam logic [CNT_W-1:0] PG_LAST    = CNT_W'(PG_DLY_CYC - 1);
  localparam logic [CNT_W-1:0] PDN_LAST   = CNT_W'(PDN_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] cnt;

  // two-flop synchronizer; resets to "pressed" so release must be observed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b00;
    else       syncQ <= {syncQ[0], onN};
  end

  assign btnLow = ~syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             seenHigh <= 1'b0;
    else if (strb.seenClr) seenHigh <= 1'b0;
    else if (!btnLow)      seenHigh <= 1'b1;
  end

  // shared saturating counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.cntClr)   cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign pressDone = (cnt == PRESS_LAST);
  assign pgDone    = (cnt == PG_LAST);
  assign pdnDone   = (cnt == PDN_LAST);
  assign longDone  = (cnt == LONG_LAST);

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       btnLow,
  input  logic       seenHigh,
  input  logic       pressDone,
  input  logic       pgDone,
  input  logic       pdnDone,
  input  logic       longDone,
  input  logic       reg1Ok,
  input  logic       reg2Ok,
  output ctlStrobe_t strb,
  output logic       reg1En,
  output logic       reg2En,
  output logic       pgRel,
  output pwrState_t  state
);

  pwrState_t nextState;
  logic      bothOk;

  assign bothOk = reg1Ok & reg2Ok;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HRST;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_HRST:  if (btnLow && seenHigh) nextState = ST_PRESS;
      ST_PRESS: begin
        if (!btnLow)        nextState = ST_HRST;
        else if (pressDone) nextState = ST_EN1;
      end
      ST_EN1:   if (reg1Ok) nextState = ST_EN2;
      ST_EN2:   if (reg2Ok) nextState = ST_PGDLY;
      ST_PGDLY: if (bothOk && pgDone) nextState = ST_ON;
      ST_ON:    if (btnLow && longDone) nextState = ST_PDN;
      ST_PDN:   if (pdnDone) nextState = ST_HRST;
      default:  nextState = ST_HRST;
    endcase
  end

  always_comb begin
    strb.cntClr  = (nextState != state)
                 || (state == ST_PGDLY && !bothOk)
                 || (state == ST_ON && !btnLow);
    strb.seenClr = (nextState == ST_PDN) && (state != ST_PDN);
  end

  assign reg1En = (state == ST_EN1) || (state == ST_EN2)
               || (state == ST_PGDLY) || (state == ST_ON);
  assign reg2En = (state == ST_EN2) || (state == ST_PGDLY) || (state == ST_ON);
  assign pgRel  = (state == ST_ON);

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned PRESS_CYC  = 400,
  parameter int unsigned PG_DLY_CYC = 230,
  parameter int unsigned PDN_CYC    = 1000,
  parameter int unsigned LONG_CYC   = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       onN,
  input  logic       reg1Ok,
  input  logic       reg2Ok,
  output logic       reg1En,
  output logic       reg2En,
  output wire        pwrGood,
  output logic [2:0] stateCode
);

  ctlStrobe_t strb;
  pwrState_t  state;
  logic btnLow, seenHigh, pressDone, pgDone, pdnDone, longDone, pgRel;

  pwr_seq_dp #(
    .PRESS_CYC(PRESS_CYC), .PG_DLY_CYC(PG_DLY_CYC),
    .PDN_CYC(PDN_CYC), .LONG_CYC(LONG_CYC)
  ) dp (
    .clk(clk), .rstN(rstN), .onN(onN), .strb(strb),
    .btnLow(btnLow), .seenHigh(seenHigh), .pressDone(pressDone),
    .pgDone(pgDone), .pdnDone(pdnDone), .longDone(longDone)
  );

  pwr_seq_fsm fsm (
    .clk(clk), .rstN(rstN), .btnLow(btnLow), .seenHigh(seenHigh),
    .pressDone(pressDone), .pgDone(pgDone), .pdnDone(pdnDone),
    .longDone(longDone), .reg1Ok(reg1Ok), .reg2Ok(reg2Ok),
    .strb(strb), .reg1En(reg1En), .reg2En(reg2En), .pgRel(pgRel),
    .state(state)
  );

  assign pwrGood   = pgRel ? 1'bz : 1'b0;
  assign stateCode = state;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int unsigned PDN_CYC = 1000
) (
  input logic       clk,
  input logic       rstN,
  input logic       reg1En,
  input logic       reg2En,
  input logic       pgRel,
  input logic [2:0] stateCode
);

  logic [31:0] pdnRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pdnRun <= '0;
    else if (stateCode == 3'd6) pdnRun <= pdnRun + 1;
    else                       pdnRun <= '0;
  end

  assert_en2_needs_en1_R4: assert property (@(posedge clk) disable iff (!rstN)
    reg2En |-> reg1En);

  assert_pg_needs_enables_R5: assert property (@(posedge clk) disable iff (!rstN)
    pgRel |-> (reg1En && reg2En));

  assert_pdn_all_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd6) |-> (!reg1En && !reg2En && !pgRel));

  assert_en1_after_press_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reg1En) |-> ($past(stateCode) == 3'd1 && !reg2En));

  assert_pdn_window_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 3'd6) |-> (pdnRun < PDN_CYC));

  assert_code_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    stateCode <= 3'd6);

endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.PDN_CYC(PDN_CYC)) chk (
  .clk(clk), .rstN(rstN), .reg1En(reg1En), .reg2En(reg2En),
  .pgRel(pgRel), .stateCode(stateCode)
);

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;

  localparam int P = 8;   // press cycles
  localparam int G = 6;   // power-good delay
  localparam int D = 10;  // power-down
  localparam int L = 12;  // long press

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onN = 1'b0;
  logic reg1Ok = 1'b0;
  logic reg2Ok = 1'b0;
  logic reg1En, reg2En;
  logic [2:0] stateCode;
  wire  pgLine;
  int   checks = 0;
  int   errors = 0;
  bit   ended = 1'b0;

  pullup (pgLine);

  pwr_seq_ctrl #(.PRESS_CYC(P), .PG_DLY_CYC(G), .PDN_CYC(D), .LONG_CYC(L)) uut (
    .clk(clk), .rstN(rstN), .onN(onN), .reg1Ok(reg1Ok), .reg2Ok(reg2Ok),
    .reg1En(reg1En), .reg2En(reg2En), .pwrGood(pgLine), .stateCode(stateCode)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // full power-up from hard reset with a clean press; checks R3/R4/R5 timing
  task automatic powerUp(input bit dropTest);
    onN = 1'b0;
    waitN(P + 1);
    onN = 1'b1;
    waitN(1);
    chk("R3 en1 not yet", int'(reg1En), 0);
    waitN(1);
    chk("R3 en1 on", int'(reg1En), 1);
    chk("R3 en2 off", int'(reg2En), 0);
    chk("R10 state en1", int'(stateCode), 2);
    waitN(3);
    chk("R4 en2 waits", int'(reg2En), 0);
    reg1Ok = 1'b1;
    waitN(1);
    chk("R4 en2 on", int'(reg2En), 1);
    chk("R10 state en2", int'(stateCode), 3);
    waitN(2);
    chk("R5 pg low", int'(pgLine), 0);
    reg2Ok = 1'b1;
    if (dropTest) begin
      waitN(3);
      chk("R6 pg low mid", int'(pgLine), 0);
      reg1Ok = 1'b0;
      waitN(2);
      chk("R6 pg held", int'(pgLine), 0);
      chk("R10 state dly", int'(stateCode), 4);
      reg1Ok = 1'b1;
      waitN(G - 1);
      chk("R6 pg restart not yet", int'(pgLine), 0);
      waitN(1);
      chk("R6 pg released", int'(pgLine), 1);
    end else begin
      waitN(G);
      chk("R5 pg not yet", int'(pgLine), 0);
      waitN(1);
      chk("R5 pg released", int'(pgLine), 1);
    end
    chk("R10 state on", int'(stateCode), 5);
  endtask

  initial begin
    // R1: reset values, button held low from reset (R2)
    waitN(3);
    chk("R1 en1", int'(reg1En), 0);
    chk("R1 en2", int'(reg2En), 0);
    chk("R1 pg", int'(pgLine), 0);
    chk("R1 state", int'(stateCode), 0);
    rstN = 1'b1;
    waitN(P + 20);
    chk("R2 no start without release", int'(reg1En), 0);
    chk("R2 state", int'(stateCode), 0);
    onN = 1'b1;
    waitN(4);

    // R3: sweep press length below the boundary
    for (int len = P - 2; len <= P; len++) begin
      onN = 1'b0;
      waitN(len);
      onN = 1'b1;
      waitN(6);
      chk("R3 short press ignored", int'(reg1En), 0);
      chk("R3 back to hard reset", int'(stateCode), 0);
    end

    powerUp(1'b1);

    // R7: long press one cycle short has no effect
    onN = 1'b0;
    waitN(L - 1);
    onN = 1'b1;
    waitN(6);
    chk("R7 short hold en1", int'(reg1En), 1);
    chk("R7 short hold pg", int'(pgLine), 1);

    // R7: full long press, keep holding through power-down
    onN = 1'b0;
    waitN(L + 1);
    chk("R7 still on", int'(reg1En), 1);
    waitN(1);
    chk("R7 en1 off", int'(reg1En), 0);
    chk("R7 en2 off", int'(reg2En), 0);
    chk("R7 pg low", int'(pgLine), 0);
    chk("R10 state pdn", int'(stateCode), 6);
    reg1Ok = 1'b0;
    reg2Ok = 1'b0;
    waitN(D - 1);
    chk("R8 still pdn", int'(stateCode), 6);
    waitN(1);
    chk("R8 hard reset", int'(stateCode), 0);
    waitN(P + 10);
    chk("R9 held button no start", int'(reg1En), 0);
    chk("R9 state", int'(stateCode), 0);
    onN = 1'b1;
    waitN(3);

    powerUp(1'b0);
    waitN(5);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finishRun();
    end
  end

endmodule